// File: doc/BRIEF.md
# Audio Coprocessor Supervisor and Sample Timer

This block sits between a host processor and a sound coprocessor that computes audio samples inside an interrupt handler. The host, on its own slower clock, writes a single control byte: seven bits choose how many coprocessor clock cycles lie between two samples, and one bit lets the coprocessor run or holds it halted. The host can also pulse a reset request, which puts the coprocessor into reset until the sample timer next expires.

In the coprocessor clock domain a reloading down-counter produces the sample tick. Each tick requests an interrupt, moves the sample the coprocessor last wrote into the DAC output register, and ends a pending coprocessor reset. The audible output therefore trails the computation by one sample. The coprocessor acknowledges the interrupt by writing its next sample. Nothing is reported back to the host. The usual bring-up runs as follows: halt the coprocessor, fill its memory, request reset, then let it run.

Top module: `audco_ctrl`

## Requirements
- R1: After the coprocessor-domain reset, `co_reset` is 1, `co_irq_n` is 1, `dac_out` is 0 and `co_ready` is 0. The timer starts with a period of 128 cycles.
- R2: The control byte is written on `host_wr`. Bit 7 is the run flag and appears on `co_ready` (1 = run, 0 = halted). Bits 6..0 are the period field. The byte crosses to the coprocessor clock through a two-stage synchronizer.
- R3: Timer ticks occur every P coprocessor cycles, where P is the period field and a field of 0 gives P = 128. A new period takes effect when the counter next reloads.
- R4: On every tick, `co_irq_n` goes low one cycle later, unless a reset request arrives in the same cycle.
- R5: `co_irq_n` stays low until a sample write (`co_smp_wr`) occurs. It returns high in the cycle after the write, unless a tick occurs in the same cycle.
- R6: On a tick while the coprocessor is not in reset, `dac_out` takes the value held in the sample buffer. The output therefore shows the sample written before the latest tick.
- R7: A `host_rst_req` strobe raises `co_reset` after crossing domains by toggle synchronization. The next tick clears `co_reset`, and `co_irq_n` goes low on that same edge.
- R8: A reset request also reloads the counter. `co_reset` therefore stays high for exactly one full period, even when the request arrives together with a tick.
- R9: While `co_reset` is high, `co_irq_n` is held high, sample writes are ignored, and `dac_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host clock |
| host_rst | input | 1 | Host-domain synchronous reset, active high |
| host_wr | input | 1 | Control byte write strobe |
| host_wdata | input | 8 | Control byte: bit 7 run flag, bits 6..0 period |
| host_rst_req | input | 1 | One-cycle request to reset the coprocessor |
| co_clk | input | 1 | Coprocessor clock |
| co_rst | input | 1 | Coprocessor-domain synchronous reset, active high |
| co_smp_wr | input | 1 | Sample write; also acknowledges the interrupt |
| co_smp_data | input | SMP_W | Sample value written by the coprocessor |
| co_ready | output | 1 | Run line to the coprocessor, 0 halts it |
| co_reset | output | 1 | Reset line to the coprocessor, active high |
| co_irq_n | output | 1 | Sample interrupt request, active low |
| dac_out | output | SMP_W | DAC output register |

## Verification
The bench builds the block with its default parameters: 8-bit samples and two synchronizer stages. The behavioural reference model assumes that latency for the control byte and for the reset toggle. Directed phases program periods of 5, 4 and 0. A field of 0 brings the 128-cycle wrap within reach, and the short periods let reset requests land on every phase of the counter, including the cycle of a tick. The host clock runs at a quarter of the coprocessor rate with offset edges, so the crossing latency is fixed.

// File: rtl/audco_pkg.sv
package audco_pkg;
    localparam int PER_W  = 7;
    localparam int CTRL_W = PER_W + 1;
    localparam int CNT_W  = PER_W + 1;

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] period;
    } ctrl_t;

    // A period field of zero selects the longest period.
    function automatic logic [CNT_W-1:0] period_len(input logic [PER_W-1:0] p);
        if (p == '0)
            return {1'b1, {PER_W{1'b0}}};
        return {1'b0, p};
    endfunction
endpackage

// File: rtl/audco_host_if.sv
module audco_host_if
    import audco_pkg::*;
(
    input  logic              host_clk,
    input  logic              host_rst,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              host_rst_req,
    output ctrl_t             ctrl_q,
    output logic              req_tog
);
    always_ff @(posedge host_clk) begin
        if (host_rst) begin
            ctrl_q  <= '0;
            req_tog <= 1'b0;
        end else begin
            if (host_wr)
                ctrl_q <= ctrl_t'(host_wdata);
            if (host_rst_req)
                req_tog <= ~req_tog;
        end
    end
endmodule

// File: rtl/audco_sync.sv
module audco_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst)
            stg <= '0;
        else
            stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/audco_timer.sv
module audco_timer
    import audco_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = (cnt == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= period_len('0);
        else if (restart || tick)
            cnt <= period_len(period);
        else
            cnt <= cnt - CNT_W'(1);
    end

    // R3: counter never leaves 1..128
    a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) && (cnt <= period_len('0)));

    // R3 / R8: a tick or a restart loads the period seen on that edge
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (tick || restart) |=> (cnt == period_len($past(period))));
endmodule

// File: rtl/audco_sample_path.sv
module audco_sample_path #(
    parameter int SMP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  logic             smp_wr,
    input  logic [SMP_W-1:0] smp_data,
    output logic             cop_reset,
    output logic             irq_n,
    output logic [SMP_W-1:0] dac_q
);
    logic [SMP_W-1:0] smp_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            cop_reset <= 1'b1;
            irq_n     <= 1'b1;
            smp_buf   <= '0;
            dac_q     <= '0;
        end else begin
            if (req)
                cop_reset <= 1'b1;
            else if (tick)
                cop_reset <= 1'b0;

            if (req)
                irq_n <= 1'b1;
            else if (tick)
                irq_n <= 1'b0;
            else if (cop_reset || smp_wr)
                irq_n <= 1'b1;

            if (smp_wr && !cop_reset)
                smp_buf <= smp_data;

            if (tick && !cop_reset)
                dac_q <= smp_buf;
        end
    end

    // R9: no interrupt request while the coprocessor is in reset
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        cop_reset |-> irq_n);

    // R9: DAC register frozen while reset is held
    a_r9_dac_hold: assert property (@(posedge clk) disable iff (rst)
        cop_reset |=> $stable(dac_q));

    // R7: reset release and interrupt coincide
    a_r7_release_irq: assert property (@(posedge clk) disable iff (rst)
        $fell(cop_reset) |-> !irq_n);

    // R4: a tick without a reset request raises the interrupt
    a_r4_tick_irq: assert property (@(posedge clk) disable iff (rst)
        (tick && !req) |=> !irq_n);

    // R5: a sample write acknowledges a pending interrupt
    a_r5_ack: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && smp_wr && !tick) |=> irq_n);
endmodule

// File: rtl/audco_ctrl.sv
module audco_ctrl
    import audco_pkg::*;
#(
    parameter int SMP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              host_clk,
    input  logic              host_rst,
    input  logic              host_wr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              host_rst_req,
    input  logic              co_clk,
    input  logic              co_rst,
    input  logic              co_smp_wr,
    input  logic [SMP_W-1:0]  co_smp_data,
    output logic              co_ready,
    output logic              co_reset,
    output logic              co_irq_n,
    output logic [SMP_W-1:0]  dac_out
);
    ctrl_t             host_ctrl;
    ctrl_t             co_ctrl;
    logic [CTRL_W-1:0] host_ctrl_raw;
    logic [CTRL_W-1:0] co_ctrl_raw;
    logic              host_tog;
    logic              co_tog;
    logic              co_tog_d;
    logic              req_pulse;
    logic              tick;

    audco_host_if u_host (
        .host_clk     (host_clk),
        .host_rst     (host_rst),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rst_req (host_rst_req),
        .ctrl_q       (host_ctrl),
        .req_tog      (host_tog)
    );

    assign host_ctrl_raw = host_ctrl;

    audco_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync_ctrl (
        .clk (co_clk),
        .rst (co_rst),
        .d   (host_ctrl_raw),
        .q   (co_ctrl_raw)
    );

    audco_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_req (
        .clk (co_clk),
        .rst (co_rst),
        .d   (host_tog),
        .q   (co_tog)
    );

    assign co_ctrl = ctrl_t'(co_ctrl_raw);

    always_ff @(posedge co_clk) begin
        if (co_rst)
            co_tog_d <= 1'b0;
        else
            co_tog_d <= co_tog;
    end

    assign req_pulse = co_tog ^ co_tog_d;

    audco_timer u_timer (
        .clk     (co_clk),
        .rst     (co_rst),
        .period  (co_ctrl.period),
        .restart (req_pulse),
        .tick    (tick)
    );

    audco_sample_path #(.SMP_W(SMP_W)) u_path (
        .clk       (co_clk),
        .rst       (co_rst),
        .tick      (tick),
        .req       (req_pulse),
        .smp_wr    (co_smp_wr),
        .smp_data  (co_smp_data),
        .cop_reset (co_reset),
        .irq_n     (co_irq_n),
        .dac_q     (dac_out)
    );

    assign co_ready = co_ctrl.run;

    // R8: a reset request always leaves the coprocessor in reset
    a_r8_req_sets: assert property (@(posedge co_clk) disable iff (co_rst)
        req_pulse |=> co_reset);
endmodule

// File: tb/audco_ctrl_tb_top.sv
`timescale 1ns/1ps
module audco_ctrl_tb_top;
    logic       host_clk = 1'b0;
    logic       co_clk = 1'b0;
    logic       host_rst = 1'b1;
    logic       co_rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rst_req = 1'b0;
    logic       co_smp_wr = 1'b0;
    logic [7:0] co_smp_data = '0;
    logic       co_ready;
    logic       co_reset;
    logic       co_irq_n;
    logic [7:0] dac_out;

    int n_checks = 0;
    int n_err = 0;
    bit cmp_en = 0;
    bit done = 0;

    // 250 MHz coprocessor clock; host at a quarter rate, edges offset by 1 ns
    always #2 co_clk = ~co_clk;
    initial begin
        #1;
        forever #8 host_clk = ~host_clk;
    end

    audco_ctrl dut_i (
        .host_clk(host_clk), .host_rst(host_rst), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rst_req(host_rst_req),
        .co_clk(co_clk), .co_rst(co_rst), .co_smp_wr(co_smp_wr),
        .co_smp_data(co_smp_data), .co_ready(co_ready), .co_reset(co_reset),
        .co_irq_n(co_irq_n), .dac_out(dac_out)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int plen(input int p);
        return (p == 0) ? 128 : p;
    endfunction

    // ---------------- reference model ----------------
    logic [7:0] m_hctrl;
    bit         m_htog;
    logic [7:0] m_s1, m_s2;
    bit         m_t1, m_t2, m_t3;
    int         m_cnt;
    bit         m_res, m_irq;
    logic [7:0] m_buf, m_dac;

    always @(posedge host_clk) begin
        if (host_rst) begin
            m_hctrl = '0;
            m_htog  = 1'b0;
        end else begin
            if (host_wr) m_hctrl = host_wdata;
            if (host_rst_req) m_htog = ~m_htog;
        end
    end

    always @(posedge co_clk) begin
        if (co_rst) begin
            m_s1 = '0; m_s2 = '0;
            m_t1 = 0; m_t2 = 0; m_t3 = 0;
            m_cnt = 128; m_res = 1; m_irq = 1;
            m_buf = '0; m_dac = '0;
        end else begin
            bit pulse, tk, n_res, n_irq;
            int n_cnt;
            logic [7:0] n_buf, n_dac;
            pulse = (m_t2 != m_t3);
            tk    = (m_cnt == 1);
            n_cnt = (pulse || tk) ? plen(int'(m_s2[6:0])) : m_cnt - 1;
            n_res = pulse ? 1'b1 : (tk ? 1'b0 : m_res);
            if (pulse)                    n_irq = 1;
            else if (tk)                  n_irq = 0;
            else if (m_res || co_smp_wr)  n_irq = 1;
            else                          n_irq = m_irq;
            n_buf = (co_smp_wr && !m_res) ? co_smp_data : m_buf;
            n_dac = (tk && !m_res) ? m_buf : m_dac;
            m_t3 = m_t2; m_t2 = m_t1; m_t1 = m_htog;
            m_s2 = m_s1; m_s1 = m_hctrl;
            m_cnt = n_cnt; m_res = n_res; m_irq = n_irq;
            m_buf = n_buf; m_dac = n_dac;
        end
    end

    // Every-cycle comparison
    always @(negedge co_clk) begin
        if (cmp_en) begin
            check("R2 co_ready vs model", int'(co_ready), int'(m_s2[7]));
            check("R7,R8 co_reset vs model", int'(co_reset), int'(m_res));
            check("R4,R5,R9 co_irq_n vs model", int'(co_irq_n), int'(m_irq));
            check("R6,R9 dac_out vs model", int'(dac_out), int'(m_dac));
        end
    end

    // Interrupt spacing monitor
    int  cyc = 0;
    int  last_fall = 0;
    int  last_gap = 0;
    bit  prev_irq = 1;
    always @(negedge co_clk) begin
        cyc++;
        if (cmp_en && prev_irq && !co_irq_n) begin
            last_gap  = cyc - last_fall;
            last_fall = cyc;
        end
        prev_irq = co_irq_n;
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_co(input int n);
        repeat (n) @(negedge co_clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge host_clk);
        host_wr = 1'b1; host_wdata = v;
        @(negedge host_clk);
        host_wr = 1'b0;
    endtask

    task automatic host_req();
        @(negedge host_clk);
        host_rst_req = 1'b1;
        @(negedge host_clk);
        host_rst_req = 1'b0;
    endtask

    task automatic serve(input logic [7:0] v);
        while (co_irq_n) @(negedge co_clk);
        co_smp_wr = 1'b1; co_smp_data = v;
        @(negedge co_clk);
        co_smp_wr = 1'b0;
    endtask

    task automatic finish_run();
        cmp_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        int n;
        logic [7:0] dac_hold;
        wait_co(6);
        host_rst = 1'b0;
        co_rst   = 1'b0;
        cmp_en   = 1;
        @(negedge co_clk);
        check("R1 reset co_reset", int'(co_reset), 1);
        check("R1 reset co_irq_n", int'(co_irq_n), 1);
        check("R1 reset dac_out", int'(dac_out), 0);
        check("R1 reset co_ready", int'(co_ready), 0);

        // halted, period 5; first tick (128 after reset) releases reset
        host_write(8'h05);
        wait_co(10);
        check("R2 halted ready", int'(co_ready), 0);
        while (co_reset) @(negedge co_clk);
        check("R7 irq with initial release", int'(co_irq_n), 0);

        host_write(8'h85);
        wait_co(8);
        check("R2 run ready", int'(co_ready), 1);

        serve(8'h11); serve(8'h22); serve(8'h33); serve(8'h44);
        check("R3 period 5 spacing", last_gap, 5);
        check("R6 dac lags one sample", int'(dac_out), 'h33);
        while (!co_irq_n) @(negedge co_clk);
        while (co_irq_n) @(negedge co_clk);
        check("R6 dac after next tick", int'(dac_out), 'h44);

        // no acknowledge: request persists across ticks
        wait_co(12);
        check("R5 irq held without ack", int'(co_irq_n), 0);
        serve(8'h55);

        // reset request: length, release irq, ignored write, held dac
        host_req();
        while (!co_reset) @(negedge co_clk);
        dac_hold = dac_out;
        co_smp_wr = 1'b1; co_smp_data = 8'h99;
        n = 0;
        while (co_reset) begin
            @(negedge co_clk);
            co_smp_wr = 1'b0;
            n++;
        end
        check("R8 reset lasts one period", n, 5);
        check("R7 irq on release", int'(co_irq_n), 0);
        check("R9 dac held through reset", int'(dac_out), int'(dac_hold));
        wait_co(5);
        check("R9 write in reset ignored", int'(dac_out), 'h55);

        // period field 0 -> 128 cycles
        host_write(8'h80);
        serve(8'h01); serve(8'h02); serve(8'h03); serve(8'h04);
        check("R3 zero field gives 128", last_gap, 128);
        check("R2 ready with zero period", int'(co_ready), 1);

        // reset requests at every counter phase, period 4
        host_write(8'h84);
        serve(8'h05); serve(8'h06);
        for (int k = 0; k < 8; k++) begin
            host_req();
            wait_co(k);
            serve(8'(8'h20 + k));
        end
        wait_co(40);
        check("R8 released after sweep", int'(co_reset), 0);

        host_write(8'h04);
        wait_co(8);
        check("R2 ready cleared", int'(co_ready), 0);

        done = 1;
        finish_run();
    end
endmodule